// File: doc/BRIEF.md
# Sampling Converter Host Bus Port

This block is a synchronous digital model of the host side of a 12-bit sampling converter that sits on a parallel bus. The host pulls chip-select and read low together. That one read cycle both starts a conversion and returns a result. The block drives an active-low busy flag for the whole conversion. It latches each finished result and presents it on a three-state data bus. The analog value arrives as a 12-bit input port and is captured on the first cycle of each conversion.

A mode input sets which result a read returns. In wait mode the bus follows the result latch. The host holds its read while busy is low, sees the previous result, and sees the new result as soon as busy returns high. In no-wait mode each read returns the result that existed when the read began. That value stays on the bus for the whole read, even if the conversion it started ends during the read. The data can be read as one 12-bit word or as two bytes. A high-byte enable input picks the upper nibble and also suppresses the start of a conversion.

Top module: `adc_host_port`

## Requirements
- R1: After reset, busy_n is high and the bus is not driven (data_oe low). The result latch is zero, so a no-wait read before any conversion returns 0.
- R2: When cs_n and rd_n go low together with hben low and no conversion running, a conversion starts and busy_n goes low.
- R3: busy_n stays low for exactly CONV_CYCLES clock cycles (default 14). It rises on the same clock edge on which the new result is latched.
- R4: A read that begins while busy_n is low is ignored. It neither restarts nor extends the running conversion.
- R5: A read with hben high never starts a conversion.
- R6: In wait mode (rom_mode = 0), the bus shows the previous result while busy_n is low. It shows the new result from the cycle in which busy_n rises, while the read is still held.
- R7: In no-wait mode (rom_mode = 1), a read returns the result that was latched when the read began. It keeps returning that value until the read ends, including after the conversion it started has finished.
- R8: With hben low, data_bus[11:0] carries the result with bit 0 on line 0, and data_bus[15:12] is 0.
- R9: With hben high, data_bus[3:0] and data_bus[11:8] both carry result bits 11..8, and all other lines are 0.
- R10: data_oe is high, and data_bus is driven, only while cs_n and rd_n are both low. Either strobe low on its own starts nothing.
- R11: The sample is taken on the first cycle of the conversion. Later changes on sample_in do not affect that conversion's result.
- R12: Each low period of the read counts as one read. Holding the read low past the end of a conversion does not start another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| hben | input | 1 | High-byte enable: 1 selects the upper nibble and blocks a start |
| rom_mode | input | 1 | 0 = wait mode, 1 = no-wait mode |
| sample_in | input | 12 | Digitised analog value |
| busy_n | output | 1 | Low while a conversion runs |
| data_oe | output | 1 | High while the data bus is driven |
| data_bus | output | 16 | Three-state result bus |

## Verification
The hardest situation to reach is a second read edge that lands inside a running conversion. Producing it takes a release and a re-assertion of the strobes, timed through the two-stage synchroniser so that the new edge arrives well before busy returns high. The bench counts negative edges from the first busy-low sample to place the release and the re-assertion. It also changes sample_in mid-conversion, then checks that the busy width, the latched value and the quiet period afterwards all match the first sample. The no-wait hold case needs a read held past the end of its own conversion. The bench sweeps such reads over a set of values that includes all-ones and zero.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    parameter int unsigned RES_W  = 12;
    parameter int unsigned BUS_W  = 16;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned HI_W  = RES_W - BYTE_W;

    typedef enum logic {
        MODE_WAIT   = 1'b0,
        MODE_NOWAIT = 1'b1
    } rd_mode_e;

    // Right-justified word; high-byte read puts the upper nibble on both
    // the low lines and its natural lines, everything else zero.
    function automatic logic [BUS_W-1:0] fmt_word(input logic [RES_W-1:0] res,
                                                  input logic hi_sel);
        logic [BUS_W-1:0] w;
        w = '0;
        if (hi_sel) begin
            w[HI_W-1:0]       = res[RES_W-1:BYTE_W];
            w[RES_W-1:BYTE_W] = res[RES_W-1:BYTE_W];
        end else begin
            w[RES_W-1:0] = res;
        end
        return w;
    endfunction
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                sh_q[i] <= RST_VAL;
            end
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/adc_port_conv.sv
module adc_port_conv #(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned CONV_CYCLES = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [RES_W-1:0] sample,
    output logic             start_ok,
    output logic             busy,
    output logic [RES_W-1:0] cap,
    output logic [RES_W-1:0] result
);
    localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [RES_W-1:0] cap;
        logic [RES_W-1:0] res;
    } conv_t;

    conv_t st_d, st_q;

    assign start_ok = start_req && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (start_ok) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
            st_d.cap  = sample;
        end else if (st_q.busy) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.res  = st_q.cap;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign cap    = st_q.cap;
    assign result = st_q.res;
endmodule

// File: rtl/adc_port_bus.sv
module adc_port_bus
    import adc_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             read_act,
    input  logic             rd_start,
    input  logic             hi_sel,
    input  rd_mode_e         mode,
    input  logic [RES_W-1:0] result,
    output logic             oe,
    output logic [BUS_W-1:0] word
);
    typedef struct packed {
        logic [RES_W-1:0] snap;
    } bus_t;

    bus_t st_d, st_q;
    logic [RES_W-1:0] shown;

    always_comb begin
        st_d = st_q;
        if (rd_start) st_d.snap = result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (mode == MODE_NOWAIT) shown = rd_start ? result : st_q.snap;
        else                     shown = result;
        word = read_act ? fmt_word(shown, hi_sel) : '0;
    end

    assign oe = read_act;
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
    import adc_port_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic             rom_mode,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy_n,
    output logic             data_oe,
    output logic [BUS_W-1:0] data_bus
);
    localparam int unsigned CTL_W = 4;

    typedef struct packed {
        logic act_prev;
    } top_t;

    logic [CTL_W-1:0] ctl_s;
    logic cs_s, rd_s, hben_s, mode_s;
    logic read_act, rd_start, conv_req, conv_start, conv_busy;
    logic [RES_W-1:0] conv_cap, conv_res;
    logic [BUS_W-1:0] bus_word;
    top_t st_d, st_q;

    adc_port_sync #(
        .W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({rom_mode, hben, rd_n, cs_n}),
        .dout(ctl_s)
    );

    assign cs_s     = ctl_s[0];
    assign rd_s     = ctl_s[1];
    assign hben_s   = ctl_s[2];
    assign mode_s   = ctl_s[3];
    assign read_act = !cs_s && !rd_s;
    assign rd_start = read_act && !st_q.act_prev;
    assign conv_req = rd_start && !hben_s;

    always_comb begin
        st_d = st_q;
        st_d.act_prev = read_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    adc_port_conv #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n),
        .start_req(conv_req), .sample(sample_in),
        .start_ok(conv_start), .busy(conv_busy),
        .cap(conv_cap), .result(conv_res)
    );

    adc_port_bus u_bus (
        .clk(clk), .rst_n(rst_n),
        .read_act(read_act), .rd_start(rd_start),
        .hi_sel(hben_s), .mode(rd_mode_e'(mode_s)),
        .result(conv_res),
        .oe(data_oe), .word(bus_word)
    );

    assign busy_n   = !conv_busy;
    assign data_bus = data_oe ? bus_word : 'z;
endmodule

// File: rtl/adc_host_port_chk.sv
module adc_host_port_chk #(
    parameter int unsigned CONV_CYCLES = 14,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned BUS_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_n,
    input logic             conv_start,
    input logic [RES_W-1:0] cap,
    input logic [RES_W-1:0] result,
    input logic             oe,
    input logic             hben_s,
    input logic [BUS_W-1:0] word
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt <= '0;
        else if (!busy_n) low_cnt <= low_cnt + 16'd1;
        else              low_cnt <= '0;
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !busy_n);

    // R3
    busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == 16'(CONV_CYCLES)));

    // R11
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && $past(!busy_n)) |-> $stable(cap));

    // R6
    prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && $past(!busy_n)) |-> $stable(result));

    // R3
    new_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (result == cap));

    // R9
    hi_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && hben_s) |-> (word[7:4] == 4'h0 && word[15:12] == 4'h0
                            && word[11:8] == word[3:0]));
endmodule

bind adc_host_port adc_host_port_chk #(
    .CONV_CYCLES(CONV_CYCLES), .RES_W(adc_port_pkg::RES_W), .BUS_W(adc_port_pkg::BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .conv_start(conv_start),
    .cap(conv_cap), .result(conv_res), .oe(data_oe), .hben_s(hben_s),
    .word(bus_word)
);

// File: tb/tb_adc_host_port.sv
module tb_adc_host_port;
    localparam int CONV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, hben = 1'b0, rom_mode = 1'b0;
    logic [11:0] sample_in = '0;
    logic        busy_n, data_oe;
    logic [15:0] data_bus;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [11:0] prev = '0;

    always #10 clk = ~clk;

    adc_host_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .rom_mode(rom_mode), .sample_in(sample_in),
        .busy_n(busy_n), .data_oe(data_oe), .data_bus(data_bus)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_on(input logic hb);
        hben = hb; cs_n = 1'b0; rd_n = 1'b0;
    endtask

    task automatic rd_off();
        cs_n = 1'b1; rd_n = 1'b1;
        idle(4);
        hben = 1'b0;
        idle(2);
    endtask

    task automatic wait_busy(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!busy_n) begin seen = 1'b1; break; end
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!busy_n && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] lo_word(input logic [11:0] v);
        return {4'h0, v};
    endfunction

    function automatic logic [15:0] hi_word(input logic [11:0] v);
        return {4'h0, v[11:8], 4'h0, v[11:8]};
    endfunction

    function automatic logic [11:0] pick(input int i);
        if (i == 0) return 12'hFFF;
        if (i == 1) return 12'h000;
        return 12'((i * 2469 + 243) % 4096);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        int n;
        logic [11:0] s, a, b;
        idle(3);
        // R1 reset state
        chk(busy_n === 1'b1, "R1 busy_n after reset", {15'h0, busy_n}, 16'h1);
        chk(data_oe === 1'b0, "R1 oe after reset", {15'h0, data_oe}, 16'h0);
        rst_n = 1'b1;
        idle(3);

        // R10 single strobes
        cs_n = 1'b1; rd_n = 1'b0; idle(6);
        chk(!data_oe && busy_n, "R10 rd only", {14'h0, data_oe, busy_n}, 16'h1);
        rd_n = 1'b1; cs_n = 1'b0; idle(6);
        chk(!data_oe && busy_n, "R10 cs only", {14'h0, data_oe, busy_n}, 16'h1);
        rd_off();

        // no-wait mode sweep; first read returns zero (R1)
        rom_mode = 1'b1; idle(4);
        for (int i = 0; i < 8; i++) begin
            s = pick(i);
            sample_in = s;
            rd_on(1'b0);
            wait_busy(seen);
            chk(seen, "R2 busy falls", {15'h0, seen}, 16'h1);
            chk(data_oe && data_bus == lo_word(prev),
                (i == 0) ? "R1 first read zero" : "R7 previous on read",
                data_bus, lo_word(prev));
            sample_in = ~s;
            count_low(n);
            chk(n == CONV, "R3 busy width", 16'(n), 16'(CONV));
            chk(data_bus == lo_word(prev), "R7 held after end", data_bus, lo_word(prev));
            idle(20);
            chk(busy_n === 1'b1, "R12 no second start", {15'h0, busy_n}, 16'h1);
            rd_off();
            chk(!data_oe, "R10 released", {15'h0, data_oe}, 16'h0);
            prev = s;
        end

        // wait mode sweep
        rom_mode = 1'b0; idle(4);
        for (int i = 0; i < 8; i++) begin
            s = pick(i + 3);
            sample_in = s;
            rd_on(1'b0);
            wait_busy(seen);
            chk(seen, "R2 busy falls", {15'h0, seen}, 16'h1);
            chk(data_oe && data_bus == lo_word(prev), "R6 previous while busy",
                data_bus, lo_word(prev));
            sample_in = ~s;
            count_low(n);
            chk(n == CONV, "R3 busy width", 16'(n), 16'(CONV));
            chk(data_bus == lo_word(s), "R6 new on busy rise", data_bus, lo_word(s));
            chk(data_bus[15:12] == 4'h0, "R8 upper lines", data_bus, lo_word(s));
            chk(data_bus == lo_word(s), "R11 sample at start", data_bus, lo_word(s));
            rd_off();
            prev = s;
            rd_on(1'b1);
            idle(4);
            chk(data_oe && data_bus == hi_word(s), "R9 high byte", data_bus, hi_word(s));
            idle(20);
            chk(busy_n === 1'b1, "R5 no start on high byte", {15'h0, busy_n}, 16'h1);
            rd_off();
        end

        // R4 second read edge inside conversion
        a = 12'hA5C; b = 12'h3B1;
        sample_in = a;
        rd_on(1'b0);
        wait_busy(seen);
        n = 1;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (k == 1) begin cs_n = 1'b1; rd_n = 1'b1; end
            if (k == 4) begin cs_n = 1'b0; rd_n = 1'b0; end
            if (k == 7) sample_in = b;
            if (busy_n) break;
            n++;
        end
        chk(n == CONV, "R4 width not extended", 16'(n), 16'(CONV));
        chk(data_bus == lo_word(a), "R4 result from first start", data_bus, lo_word(a));
        idle(20);
        chk(busy_n === 1'b1, "R4 no restart", {15'h0, busy_n}, 16'h1);
        rd_off();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule